// File: doc/BRIEF.md
# Modem Control and Status Register Pair

This block holds the modem control and modem status registers of a 16550-class serial port. Each clock it samples the four modem inputs: carrier detect, ring indicator, data-set-ready and clear-to-send. It compares each sample with the level it registered on the previous cycle and latches any change into a sticky change flag. For the ring line, only the end of a ring (a 1-to-0 edge) is flagged. The host reads the status byte through a combinational read port. A read strobe clears the change flags.

The control register keeps five bits. Two of them drive the request-to-send and data-terminal-ready outputs. One bit selects loopback. In loopback the four control outputs appear on the upper half of the status byte in place of the pins. The outward control outputs are then held inactive, and pin activity is not flagged. A modem-status interrupt request is raised while the interrupt-enable input is set and any change flag is pending.

Top module: `uart_modem_status`

## Requirements
- R1: After reset the control register reads 0x08 (OUT2 only) and the status byte reads 0xB0. The interrupt request, `rts_o` and `dtr_o` are low.
- R2: Outside loopback the status byte places the levels sampled on the previous clock as carrier bit 7, ring bit 6, data-set-ready bit 5 and clear-to-send bit 4. A change of clear-to-send, data-set-ready or carrier against the previous sample sets change flag bit 0, bit 1 or bit 3 respectively, visible the cycle after the change.
- R3: Change flag bit 2 is set only when the ring input goes from 1 to 0. A 0-to-1 ring edge sets no flag.
- R4: Change flags stay set until a status read outside loopback clears all four. A change sampled in the same cycle as the read leaves its flag set.
- R5: A control write stores bits 4:0 (bit 4 loopback, bit 3 OUT2, bit 2 OUT1, bit 1 RTS, bit 0 DTR), readable on `ctl_rd` from the next cycle.
- R6: Outside loopback `rts_o` equals control bit 1 and `dtr_o` equals control bit 0. In loopback both are 0.
- R7: In loopback the status byte reads OUT2 as bit 7, OUT1 as bit 6, DTR as bit 5 and RTS as bit 4, with bits 3:0 reading 0.
- R8: While loopback is set, pin changes set no change flags. Flags pending before loopback are visible again after leaving it.
- R9: `irq_o` is high exactly when `ier_ms_en` is high and at least one change flag is pending.
- R10: A status read while loopback is set leaves pending change flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_ctl | input | 1 | Control register write strobe |
| ctl_wdata | input | 5 | Control register write data |
| rd_stat | input | 1 | Status read strobe (clears change flags) |
| ier_ms_en | input | 1 | Modem-status interrupt enable |
| cts_i | input | 1 | Clear-to-send input (already synchronised) |
| dsr_i | input | 1 | Data-set-ready input |
| dcd_i | input | 1 | Carrier detect input |
| ri_i | input | 1 | Ring indicator input |
| ctl_rd | output | 5 | Current control register value |
| rd_data | output | 8 | Status byte as seen by a read |
| rts_o | output | 1 | Request-to-send output |
| dtr_o | output | 1 | Data-terminal-ready output |
| irq_o | output | 1 | Modem-status interrupt request |

## Verification
The bench builds the block with its default parameters: four modem lines, with only the ring line in trailing-edge mode. That setting brings both flag rules within reach: the plain change rule on three lines and the falling-only rule on the ring line. Directed sequences cover a ring rise versus a ring fall, and a read that coincides with a change. They also enter loopback with a flag already pending and toggle pins while looped back. Random traffic then mixes reads, control writes and pin toggles in and out of loopback.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  localparam int NLINES = 4;
  localparam int CTL_W  = 5;
  localparam int STAT_W = 2 * NLINES;

  typedef logic [NLINES-1:0] line_vec_t;
  typedef logic [CTL_W-1:0]  ctl_vec_t;

  // line vector order: 3 carrier, 2 ring, 1 data-set-ready, 0 clear-to-send
  localparam int LN_CTS = 0;
  localparam int LN_DSR = 1;
  localparam int LN_RI  = 2;
  localparam int LN_DCD = 3;

  // control bit positions
  localparam int CB_DTR  = 0;
  localparam int CB_RTS  = 1;
  localparam int CB_OUT1 = 2;
  localparam int CB_OUT2 = 3;
  localparam int CB_LOOP = 4;

  localparam line_vec_t LINE_RST   = 4'b1011;
  localparam line_vec_t TRAIL_MASK = 4'b0100;
  localparam ctl_vec_t  CTL_RST    = 5'b01000;
endpackage

// File: rtl/mdm_ctl_reg.sv
module mdm_ctl_reg
  import mdm_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_en,
  input  ctl_vec_t wdata,
  output ctl_vec_t ctl_q,
  output logic     loop_q
);
  ctl_vec_t ctl_d;

  always_comb begin
    ctl_d = ctl_q;
    if (wr_en) ctl_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= CTL_RST;
    else        ctl_q <= ctl_d;
  end

  assign loop_q = ctl_q[CB_LOOP];
endmodule

// File: rtl/mdm_line_track.sv
module mdm_line_track
  import mdm_pkg::*;
#(
  parameter line_vec_t RST_LEVEL = LINE_RST,
  parameter line_vec_t FALL_ONLY = TRAIL_MASK
) (
  input  logic      clk,
  input  logic      rst_n,
  input  line_vec_t pins,
  input  logic      loop_en,
  input  logic      rd_clr,
  output line_vec_t level_q,
  output line_vec_t delta_q
);
  line_vec_t set_vec;
  line_vec_t delta_d;

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    if (FALL_ONLY[i]) begin : g_fall
      assign set_vec[i] = !loop_en && level_q[i] && !pins[i];
    end else begin : g_any
      assign set_vec[i] = !loop_en && (level_q[i] ^ pins[i]);
    end
  end

  always_comb begin
    delta_d = delta_q;
    if (rd_clr && !loop_en) delta_d = '0;
    delta_d = delta_d | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= RST_LEVEL;
      delta_q <= '0;
    end else begin
      level_q <= pins;
      delta_q <= delta_d;
    end
  end
endmodule

// File: rtl/mdm_stat_mux.sv
module mdm_stat_mux
  import mdm_pkg::*;
(
  input  ctl_vec_t          ctl_q,
  input  line_vec_t         level_q,
  input  line_vec_t         delta_q,
  input  logic              ier_ms_en,
  output logic [STAT_W-1:0] stat,
  output logic              rts,
  output logic              dtr,
  output logic              irq
);
  line_vec_t loop_lines;

  always_comb begin
    loop_lines         = '0;
    loop_lines[LN_DCD] = ctl_q[CB_OUT2];
    loop_lines[LN_RI]  = ctl_q[CB_OUT1];
    loop_lines[LN_DSR] = ctl_q[CB_DTR];
    loop_lines[LN_CTS] = ctl_q[CB_RTS];
    if (ctl_q[CB_LOOP]) stat = {loop_lines, {NLINES{1'b0}}};
    else                stat = {level_q, delta_q};
    rts = ctl_q[CB_RTS] && !ctl_q[CB_LOOP];
    dtr = ctl_q[CB_DTR] && !ctl_q[CB_LOOP];
    irq = ier_ms_en && (|delta_q);
  end
endmodule

// File: rtl/uart_modem_status.sv
module uart_modem_status
  import mdm_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_ctl,
  input  logic [CTL_W-1:0]      ctl_wdata,
  input  logic                  rd_stat,
  input  logic                  ier_ms_en,
  input  logic                  cts_i,
  input  logic                  dsr_i,
  input  logic                  dcd_i,
  input  logic                  ri_i,
  output logic [CTL_W-1:0]      ctl_rd,
  output logic [STAT_W-1:0]     rd_data,
  output logic                  rts_o,
  output logic                  dtr_o,
  output logic                  irq_o
);
  ctl_vec_t  ctl_q;
  logic      loop_q;
  line_vec_t pins;
  line_vec_t level_q;
  line_vec_t delta_q;

  always_comb begin
    pins         = '0;
    pins[LN_CTS] = cts_i;
    pins[LN_DSR] = dsr_i;
    pins[LN_RI]  = ri_i;
    pins[LN_DCD] = dcd_i;
  end

  mdm_ctl_reg u_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_ctl), .wdata(ctl_wdata),
    .ctl_q(ctl_q), .loop_q(loop_q)
  );

  mdm_line_track #(.RST_LEVEL(LINE_RST), .FALL_ONLY(TRAIL_MASK)) u_trk (
    .clk(clk), .rst_n(rst_n), .pins(pins), .loop_en(loop_q),
    .rd_clr(rd_stat), .level_q(level_q), .delta_q(delta_q)
  );

  mdm_stat_mux u_mux (
    .ctl_q(ctl_q), .level_q(level_q), .delta_q(delta_q),
    .ier_ms_en(ier_ms_en), .stat(rd_data), .rts(rts_o), .dtr(dtr_o),
    .irq(irq_o)
  );

  assign ctl_rd = ctl_q;
endmodule

// File: rtl/uart_modem_status_chk.sv
module uart_modem_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_ctl,
  input logic       rd_stat,
  input logic       ier_ms_en,
  input logic       cts_i,
  input logic       dsr_i,
  input logic       dcd_i,
  input logic       ri_i,
  input logic [4:0] ctl_rd,
  input logic [7:0] rd_data,
  input logic       rts_o,
  input logic       dtr_o,
  input logic       irq_o
);
  a_r2_cts_change: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_rd[4] && cts_i != rd_data[4]) |=> rd_data[0] || ctl_rd[4]);

  a_r2_dcd_change: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_rd[4] && dcd_i != rd_data[7]) |=> rd_data[3] || ctl_rd[4]);

  a_r3_ri_rise_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !ctl_rd[4] && !wr_ctl && !rd_data[6] && ri_i) |=> !rd_data[2]);

  a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !ctl_rd[4] && !wr_ctl &&
     {dcd_i, ri_i, dsr_i, cts_i} == rd_data[7:4]) |=> rd_data[3:0] == 4'h0);

  a_r6_loop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rd[4] |-> (!rts_o && !dtr_o));

  a_r7_loop_map: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rd[4] |-> rd_data == {ctl_rd[3], ctl_rd[2], ctl_rd[0], ctl_rd[1], 4'h0});

  a_r9_irq: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_rd[4] |-> irq_o == (ier_ms_en && (rd_data[3:0] != 4'h0)));

  a_r9_irq_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    !ier_ms_en |-> !irq_o);
endmodule

bind uart_modem_status uart_modem_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_ctl(wr_ctl), .rd_stat(rd_stat),
  .ier_ms_en(ier_ms_en), .cts_i(cts_i), .dsr_i(dsr_i), .dcd_i(dcd_i),
  .ri_i(ri_i), .ctl_rd(ctl_rd), .rd_data(rd_data), .rts_o(rts_o),
  .dtr_o(dtr_o), .irq_o(irq_o)
);

// File: tb/sim_uart_modem_status.sv
`timescale 1ns/1ps
module sim_uart_modem_status;
  logic       clk;
  logic       rst_n;
  logic       wr_ctl;
  logic [4:0] ctl_wdata;
  logic       rd_stat;
  logic       ier_ms_en;
  logic       cts_i, dsr_i, dcd_i, ri_i;
  logic [4:0] ctl_rd;
  logic [7:0] rd_data;
  logic       rts_o, dtr_o, irq_o;

  int n_chk;
  int n_bad;
  bit done;

  // bench model state
  logic [4:0] m_ctl;
  logic [3:0] m_lvl;   // {dcd, ri, dsr, cts}
  logic [3:0] m_dlt;

  uart_modem_status u0 (
    .clk(clk), .rst_n(rst_n), .wr_ctl(wr_ctl), .ctl_wdata(ctl_wdata),
    .rd_stat(rd_stat), .ier_ms_en(ier_ms_en), .cts_i(cts_i), .dsr_i(dsr_i),
    .dcd_i(dcd_i), .ri_i(ri_i), .ctl_rd(ctl_rd), .rd_data(rd_data),
    .rts_o(rts_o), .dtr_o(dtr_o), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [7:0] exp_stat(logic [4:0] c, logic [3:0] l, logic [3:0] d);
    if (c[4]) return {c[3], c[2], c[0], c[1], 4'h0};
    return {l, d};
  endfunction

  function automatic logic [3:0] exp_set(logic loop, logic [3:0] l, logic [3:0] p);
    logic [3:0] s;
    if (loop) return 4'h0;
    s    = l ^ p;
    s[2] = l[2] && !p[2];
    return s;
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%02h expected=0x%02h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all(string stag);
    chk(stag, rd_data, exp_stat(m_ctl, m_lvl, m_dlt));
    chk("R5 ctl", {3'b0, ctl_rd}, {3'b0, m_ctl});
    chk("R6 rts", {7'b0, rts_o}, {7'b0, m_ctl[1] && !m_ctl[4]});
    chk("R6 dtr", {7'b0, dtr_o}, {7'b0, m_ctl[0] && !m_ctl[4]});
    chk("R9 irq", {7'b0, irq_o}, {7'b0, ier_ms_en && (m_dlt != 4'h0)});
  endtask

  // apply inputs at negedge, update model for the coming posedge, wait and check
  task automatic step(logic [3:0] p, logic rd, logic wr, logic [4:0] wd, logic ie, string stag);
    logic [3:0] s;
    {dcd_i, ri_i, dsr_i, cts_i} = p;
    rd_stat   = rd;
    wr_ctl    = wr;
    ctl_wdata = wd;
    ier_ms_en = ie;
    s = exp_set(m_ctl[4], m_lvl, p);
    if (rd && !m_ctl[4]) m_dlt = 4'h0;
    m_dlt = m_dlt | s;
    m_lvl = p;
    if (wr) m_ctl = wd;
    @(posedge clk);
    @(negedge clk);
    rd_stat = 1'b0;
    wr_ctl  = 1'b0;
    check_all(stag);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    n_chk = 0; n_bad = 0; done = 1'b0;
    seed = $urandom(32'h5eed_1234);
    rst_n = 1'b0; wr_ctl = 1'b0; ctl_wdata = '0; rd_stat = 1'b0; ier_ms_en = 1'b1;
    {dcd_i, ri_i, dsr_i, cts_i} = 4'b1011;
    m_ctl = 5'b01000; m_lvl = 4'b1011; m_dlt = 4'h0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 stat", rd_data, 8'hB0);
    chk("R1 ctl", {3'b0, ctl_rd}, 8'h08);
    chk("R1 irq/rts/dtr", {5'b0, irq_o, rts_o, dtr_o}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 after release");

    // R5/R6: drive RTS and DTR
    step(4'b1011, 0, 1, 5'b00011, 1, "R5 write");
    // R2: clear-to-send drops -> 0xA1; R9 irq high
    step(4'b1010, 0, 0, 5'b0, 1, "R2 cts");
    chk("R2 cts flag", rd_data, 8'hA1);
    chk("R9 irq set", {7'b0, irq_o}, 8'h01);
    // R4: read clears
    step(4'b1010, 1, 0, 5'b0, 1, "R4 read");
    chk("R4 cleared", rd_data, 8'hA0);
    // R3: ring rise flags nothing, ring fall sets bit 2
    step(4'b1110, 0, 0, 5'b0, 1, "R3 rise");
    chk("R3 rise", rd_data, 8'hE0);
    step(4'b1010, 0, 0, 5'b0, 1, "R3 fall");
    chk("R3 fall", rd_data, 8'hA4);
    // R4: read in the same cycle as a carrier change keeps the new flag
    step(4'b0010, 1, 0, 5'b0, 1, "R4 read+change");
    chk("R4 read+change", rd_data, 8'h28);
    // R8/R10: enter loopback with a pending flag, toggle pins, read, leave
    step(4'b0010, 0, 1, 5'b10110, 0, "R7 enter");
    chk("R7 map", rd_data, 8'h50);
    chk("R6 loop outs", {6'b0, rts_o, dtr_o}, 8'h00);
    step(4'b1101, 1, 0, 5'b0, 1, "R10 loop read");
    chk("R9 irq held in loop", {7'b0, irq_o}, 8'h01);
    step(4'b0010, 0, 0, 5'b0, 1, "R8 loop toggle");
    step(4'b0010, 0, 1, 5'b01011, 1, "R8 exit");
    chk("R8 R10 flag kept", rd_data, 8'h28);

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] p;
      logic [4:0] wd;
      logic rd, wr, ie;
      p  = {dcd_i, ri_i, dsr_i, cts_i} ^ (4'($urandom) & 4'($urandom));
      rd = ($urandom % 3) == 0;
      wr = ($urandom % 8) == 0;
      wd = 5'($urandom);
      if (($urandom % 3) != 0) wd[4] = 1'b0;
      ie = ($urandom % 4) != 0;
      step(p, rd, wr, wd, ie, m_ctl[4] ? "R7 random" : "R2 R3 R4 random");
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule